// File: doc/BRIEF.md
# Stale Receive Data Timer with Residual-Byte Status

This block sits beside a receive FIFO and its output pipeline and decides when buffered bytes have to be handed onward after the incoming stream goes quiet. A down-counter is loaded from a programmable period each time the port writes a byte into the FIFO. When the count runs out, the data becomes stale. If at least two bytes are waiting, the block raises a DMA request.

DMA can only move pairs of bytes. A single byte that is left over is therefore flagged through a latched one-character status and a CPU interrupt. While that status is set, the pipeline is frozen, and any newly arriving bytes stay in the FIFO until the CPU reads the final pipeline register. The block also keeps a latched timeout status, and it combines timeout and one-character into one interrupt line under separate enables.

The occupancy of the FIFO, of the DMA buffer and of the final pipeline register is supplied by the surrounding datapath. The DMA engine and the register bus are outside this block.

Top module: `stale_mon`

## Requirements
- R1: Every FIFO write (fifo_wr_i high at a clock edge) reloads the counter from period_i, clears stale, and restarts the count. With no further writes, stale_o rises exactly period_i+1 clock edges after the write edge.
- R2: While stale_dis_i is high, stale_o and dma_req_o are low even though the counter has expired. The expiry is remembered: lowering stale_dis_i afterwards shows stale_o high at once.
- R3: The available count is fifo_cnt_i + dma_cnt_i + last_full_i. dma_req_o is high exactly when stale_o is high, that count is at least 2, and one_char_o is low.
- R4: one_char_o sets at the clock edge after stale_o is high while fifo_cnt_i is 0, dma_cnt_i is 0 and last_full_i is 1. It stays set until it is cleared.
- R5: pipe_hold_o is high whenever one_char_o is high, which blocks pipeline advancement.
- R6: A last_rd_i pulse (CPU read of the final pipeline register) or a fifo_rst_i pulse clears one_char_o and pipe_hold_o at that edge. Clearing wins over setting.
- R7: timeout_o sets at the edge where the counter expires, if stale_o is low and neither clr_to_i nor fifo_rst_i is high at that edge. Once set, it is cleared only by clr_to_i or fifo_rst_i. fifo_rst_i also clears the counter and stale.
- R8: irq_o = (one_char_o AND ie_one_i) OR (timeout_o AND ie_to_i).
- R9: fifo_empty_o is high when fifo_cnt_i is 0 and no write has arrived since one_char_o was latched. A write while one_char_o is high forces fifo_empty_o low until one_char_o clears.
- R10: After reset, stale_o, one_char_o, timeout_o, pipe_hold_o, dma_req_o and irq_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fifo_wr_i | input | 1 | Byte written into the FIFO from the port |
| fifo_cnt_i | input | FCNT_W | Bytes currently in the FIFO |
| dma_cnt_i | input | DCNT_W | Bytes in the DMA staging buffer |
| last_full_i | input | 1 | Final pipeline register holds a byte |
| last_rd_i | input | 1 | CPU read of the final pipeline register |
| period_i | input | TMR_W | Stale period reload value |
| stale_dis_i | input | 1 | Suppress stale status |
| clr_to_i | input | 1 | Clear timeout status |
| fifo_rst_i | input | 1 | FIFO reset, clears all latched state |
| ie_to_i | input | 1 | Timeout interrupt enable |
| ie_one_i | input | 1 | One-character interrupt enable |
| stale_o | output | 1 | Stale status |
| one_char_o | output | 1 | One residual byte status |
| timeout_o | output | 1 | Latched timeout status |
| fifo_empty_o | output | 1 | FIFO-empty status |
| pipe_hold_o | output | 1 | Pipeline advancement blocked |
| dma_req_o | output | 1 | DMA transfer request |
| irq_o | output | 1 | CPU interrupt |

## Verification
Every period from 0 to 7 is used with a single write, and one restart in the middle of a count, to separate off-by-one reload timing from missed restarts. At expiry, all combinations of FIFO count 0–3, DMA buffer 0–2 and final-register occupancy are applied. This shows the pair-capable cases (DMA request) apart from the lone-byte case (one-character latch, hold and interrupt) and from the empty case. Separate sequences check the clear-timeout bit held across an expiry, stale suppression with later release, interrupt masking, and a write that arrives during the hold followed by the CPU read that releases it.

// File: rtl/stale_mon_pkg.sv
package stale_mon_pkg;
  typedef struct packed {
    logic stale;
    logic one_char;
    logic timeout;
    logic fifo_empty;
  } stat_t;
endpackage

// File: rtl/stale_tmr.sv
module stale_tmr #(
  parameter int TMR_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic             flush_i,
  input  logic [TMR_W-1:0] period_i,
  output logic             stale_o,
  output logic             tick_o
);
  logic [TMR_W-1:0] cnt_q;
  logic             run_q;
  logic             stale_q;

  assign tick_o  = run_q && (cnt_q == '0) && !wr_i && !flush_i;
  assign stale_o = stale_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      run_q   <= 1'b0;
      stale_q <= 1'b0;
    end else if (flush_i) begin
      cnt_q   <= '0;
      run_q   <= 1'b0;
      stale_q <= 1'b0;
    end else if (wr_i) begin
      cnt_q   <= period_i;
      run_q   <= 1'b1;
      stale_q <= 1'b0;
    end else if (run_q) begin
      if (cnt_q == '0) begin
        run_q   <= 1'b0;
        stale_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q - TMR_W'(1);
      end
    end
  end
endmodule

// File: rtl/resid_ctl.sv
module resid_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic rd_i,
  input  logic flush_i,
  input  logic wr_i,
  output logic one_char_o,
  output logic arrived_o
);
  logic one_q, arr_q;
  logic clr;

  assign clr        = rd_i || flush_i;
  assign one_char_o = one_q;
  assign arrived_o  = arr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      one_q <= 1'b0;
      arr_q <= 1'b0;
    end else if (clr) begin
      one_q <= 1'b0;
      arr_q <= 1'b0;
    end else begin
      if (set_i) one_q <= 1'b1;
      if (one_q && wr_i) arr_q <= 1'b1;
    end
  end
endmodule

// File: rtl/to_stat.sv
module to_stat (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic stale_i,
  input  logic clr_i,
  input  logic flush_i,
  output logic timeout_o
);
  logic to_q;
  assign timeout_o = to_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                to_q <= 1'b0;
    else if (clr_i || flush_i)  to_q <= 1'b0;
    else if (tick_i && !stale_i) to_q <= 1'b1;
  end
endmodule

// File: rtl/stale_mon.sv
module stale_mon #(
  parameter int TMR_W  = 8,
  parameter int FCNT_W = 5,
  parameter int DCNT_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fifo_wr_i,
  input  logic [FCNT_W-1:0] fifo_cnt_i,
  input  logic [DCNT_W-1:0] dma_cnt_i,
  input  logic              last_full_i,
  input  logic              last_rd_i,
  input  logic [TMR_W-1:0]  period_i,
  input  logic              stale_dis_i,
  input  logic              clr_to_i,
  input  logic              fifo_rst_i,
  input  logic              ie_to_i,
  input  logic              ie_one_i,
  output logic              stale_o,
  output logic              one_char_o,
  output logic              timeout_o,
  output logic              fifo_empty_o,
  output logic              pipe_hold_o,
  output logic              dma_req_o,
  output logic              irq_o
);
  import stale_mon_pkg::*;

  localparam int AV_W = ((FCNT_W > DCNT_W) ? FCNT_W : DCNT_W) + 2;

  stat_t            st;
  logic             stale_raw, tick, arrived, one_set;
  logic [AV_W-1:0]  avail;

  stale_tmr #(.TMR_W(TMR_W)) u_tmr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (fifo_wr_i),
    .flush_i  (fifo_rst_i),
    .period_i (period_i),
    .stale_o  (stale_raw),
    .tick_o   (tick)
  );

  assign st.stale = stale_raw && !stale_dis_i;
  assign avail    = AV_W'(fifo_cnt_i) + AV_W'(dma_cnt_i) + AV_W'(last_full_i);
  // lone byte parked in the final register, nothing behind it
  assign one_set  = st.stale && (fifo_cnt_i == '0) && (dma_cnt_i == '0) && last_full_i;

  resid_ctl u_resid (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .set_i      (one_set),
    .rd_i       (last_rd_i),
    .flush_i    (fifo_rst_i),
    .wr_i       (fifo_wr_i),
    .one_char_o (st.one_char),
    .arrived_o  (arrived)
  );

  to_stat u_to (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick),
    .stale_i   (st.stale),
    .clr_i     (clr_to_i),
    .flush_i   (fifo_rst_i),
    .timeout_o (st.timeout)
  );

  assign st.fifo_empty = (fifo_cnt_i == '0) && !arrived;

  assign stale_o      = st.stale;
  assign one_char_o   = st.one_char;
  assign timeout_o    = st.timeout;
  assign fifo_empty_o = st.fifo_empty;
  assign pipe_hold_o  = st.one_char;
  assign dma_req_o    = st.stale && (avail >= AV_W'(2)) && !st.one_char;
  assign irq_o        = (st.one_char && ie_one_i) || (st.timeout && ie_to_i);
endmodule

// File: rtl/stale_mon_chk.sv
module stale_mon_chk #(
  parameter int TMR_W  = 8,
  parameter int FCNT_W = 5,
  parameter int DCNT_W = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              fifo_wr_i,
  input logic [FCNT_W-1:0] fifo_cnt_i,
  input logic [DCNT_W-1:0] dma_cnt_i,
  input logic              last_full_i,
  input logic              last_rd_i,
  input logic [TMR_W-1:0]  period_i,
  input logic              stale_dis_i,
  input logic              clr_to_i,
  input logic              fifo_rst_i,
  input logic              ie_to_i,
  input logic              ie_one_i,
  input logic              stale_o,
  input logic              one_char_o,
  input logic              timeout_o,
  input logic              fifo_empty_o,
  input logic              pipe_hold_o,
  input logic              dma_req_o,
  input logic              irq_o
);
  // R1
  wr_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_wr_i |=> !stale_o);
  // R2
  dis_no_dma_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stale_dis_i |-> !dma_req_o);
  // R3
  one_no_dma_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    one_char_o |-> !dma_req_o);
  // R4
  one_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stale_o && fifo_cnt_i == '0 && dma_cnt_i == '0 && last_full_i && !last_rd_i && !fifo_rst_i)
    |=> one_char_o);
  // R5
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    one_char_o |-> pipe_hold_o);
  // R6
  rd_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last_rd_i || fifo_rst_i) |=> !one_char_o);
  // R7
  to_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (timeout_o && !clr_to_i && !fifo_rst_i) |=> timeout_o);
  // R7
  to_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_to_i |=> !timeout_o);
  // R8
  irq_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ((one_char_o && ie_one_i) || (timeout_o && ie_to_i)));
  // R9
  arrive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (one_char_o && fifo_wr_i && !last_rd_i && !fifo_rst_i) |=> !fifo_empty_o);
endmodule

bind stale_mon stale_mon_chk #(.TMR_W(TMR_W), .FCNT_W(FCNT_W), .DCNT_W(DCNT_W)) u_chk (.*);

// File: tb/tb_stale_mon.sv
module tb_stale_mon;
  localparam int CLK_PERIOD = 10;
  localparam int TMR_W = 8, FCNT_W = 5, DCNT_W = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic fifo_wr = 0, last_full = 0, last_rd = 0, stale_dis = 0;
  logic clr_to = 0, fifo_rst = 0, ie_to = 0, ie_one = 0;
  logic [FCNT_W-1:0] fifo_cnt = '0;
  logic [DCNT_W-1:0] dma_cnt = '0;
  logic [TMR_W-1:0]  period = '0;
  logic stale, one_char, timeout, fifo_empty, pipe_hold, dma_req, irq;
  int total = 0, bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  stale_mon #(.TMR_W(TMR_W), .FCNT_W(FCNT_W), .DCNT_W(DCNT_W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .fifo_wr_i(fifo_wr), .fifo_cnt_i(fifo_cnt),
    .dma_cnt_i(dma_cnt), .last_full_i(last_full), .last_rd_i(last_rd),
    .period_i(period), .stale_dis_i(stale_dis), .clr_to_i(clr_to),
    .fifo_rst_i(fifo_rst), .ie_to_i(ie_to), .ie_one_i(ie_one),
    .stale_o(stale), .one_char_o(one_char), .timeout_o(timeout),
    .fifo_empty_o(fifo_empty), .pipe_hold_o(pipe_hold), .dma_req_o(dma_req),
    .irq_o(irq));

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse_wr();
    fifo_wr = 1; @(negedge clk); fifo_wr = 0;
  endtask

  task automatic flush();
    fifo_rst = 1; @(negedge clk); fifo_rst = 0;
  endtask

  // cycles from the write edge until stale_o rises
  task automatic stale_lat(output int lat);
    lat = -1;
    for (int n = 1; n < 300; n++) begin
      @(negedge clk);
      if (stale) begin lat = n; break; end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int lat;
    repeat (2) @(negedge clk);
    // R10 reset state
    check("R10 stale", stale, 0);
    check("R10 one_char", one_char, 0);
    check("R10 timeout", timeout, 0);
    check("R10 hold", pipe_hold, 0);
    check("R10 dma", dma_req, 0);
    check("R10 irq", irq, 0);
    rst_n = 1;
    @(negedge clk);

    // R1 latency sweep
    for (int p = 0; p < 8; p++) begin
      flush();
      period = TMR_W'(p);
      pulse_wr();
      stale_lat(lat);
      check("R1 latency", lat, p + 1);
    end
    // R1 restart in the middle of a count
    flush();
    period = 5;
    pulse_wr();
    repeat (3) @(negedge clk);
    check("R1 not yet stale", stale, 0);
    pulse_wr();
    stale_lat(lat);
    check("R1 restart latency", lat, 6);

    // R3 R4 R5 R6 R8 occupancy sweep at expiry
    ie_one = 1; ie_to = 0;
    for (int fc = 0; fc < 4; fc++)
      for (int dc = 0; dc < 3; dc++)
        for (int lf = 0; lf < 2; lf++) begin
          int exp_one, exp_dma;
          fifo_cnt = '0; dma_cnt = '0; last_full = 0;
          flush();
          period = 1;
          pulse_wr();
          repeat (3) @(negedge clk);
          check("R1 stale up", stale, 1);
          fifo_cnt = FCNT_W'(fc); dma_cnt = DCNT_W'(dc); last_full = lf[0];
          @(negedge clk);
          exp_one = (fc == 0 && dc == 0 && lf == 1) ? 1 : 0;
          exp_dma = (fc + dc + lf >= 2) ? 1 : 0;
          check("R3 dma_req", dma_req, exp_dma);
          check("R4 one_char", one_char, exp_one);
          check("R5 hold", pipe_hold, exp_one);
          check("R8 irq one", irq, exp_one);
          if (exp_one == 1) begin
            last_rd = 1; @(negedge clk); last_rd = 0;
            check("R6 read clears", one_char, 0);
            check("R6 hold released", pipe_hold, 0);
          end
        end
    ie_one = 0;
    check("R8 masked one", irq, 0);
    fifo_cnt = '0; dma_cnt = '0; last_full = 0;

    // R9 write during hold
    flush();
    period = 2;
    pulse_wr();
    repeat (4) @(negedge clk);
    last_full = 1;
    @(negedge clk);
    check("R4 latched", one_char, 1);
    check("R9 empty before", fifo_empty, 1);
    pulse_wr();
    check("R9 empty after arrival", fifo_empty, 0);
    check("R5 hold kept", pipe_hold, 1);
    last_rd = 1; @(negedge clk); last_rd = 0;
    last_full = 0;
    check("R6 release", one_char, 0);
    check("R9 empty restored", fifo_empty, 1);

    // R6 fifo reset clears one_char
    period = 0;
    pulse_wr();
    repeat (2) @(negedge clk);
    last_full = 1;
    @(negedge clk);
    check("R4 latched again", one_char, 1);
    last_full = 0;
    flush();
    check("R6 fifo reset clears", one_char, 0);

    // R7 timeout
    flush();
    clr_to = 1;
    period = 2;
    pulse_wr();
    repeat (4) @(negedge clk);
    check("R7 clr blocks set", timeout, 0);
    clr_to = 0;
    pulse_wr();
    stale_lat(lat);
    check("R7 timeout set", timeout, 1);
    check("R8 irq masked to", irq, 0);
    ie_to = 1;
    @(negedge clk);
    check("R8 irq timeout", irq, 1);
    pulse_wr();
    check("R7 held across write", timeout, 1);
    clr_to = 1; @(negedge clk); clr_to = 0;
    check("R7 clr clears", timeout, 0);
    check("R8 irq drops", irq, 0);
    stale_lat(lat);
    check("R7 set again", timeout, 1);
    flush();
    check("R7 fifo reset clears", timeout, 0);
    check("R7 fifo reset clears stale", stale, 0);
    ie_to = 0;

    // R2 stale suppression
    stale_dis = 1;
    fifo_cnt = 4;
    period = 3;
    pulse_wr();
    repeat (6) @(negedge clk);
    check("R2 stale held low", stale, 0);
    check("R2 no dma", dma_req, 0);
    check("R7 timeout under disable", timeout, 1);
    stale_dis = 0;
    @(negedge clk);
    check("R2 stale after release", stale, 1);
    check("R3 dma after release", dma_req, 1);
    fifo_cnt = '0;

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule